// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a serial peripheral interface (SPI) master that software drives through a 32-bit register port. Software fills a byte queue for outgoing data, programs how many bytes the exchange lasts, and how many of them come from the queue. It then sets a start flag. The block shifts the bytes out most significant bit first, captures one incoming byte for each byte sent into a second queue, and clears the start flag by itself when the last byte is complete. Software polls either the start flag or the fill level of the receive queue, then drains the received bytes one per read.

The serial clock is divided down from the system clock. Its idle level and its sampling edge follow two mode bits. Four select lines are available. The selected line is asserted automatically for the length of an exchange, or driven by software to a fixed level. Two self-clearing bits empty the queues. A self-clearing reset bit aborts any exchange. A pause bit stops the engine between bytes while the receive queue is full.

Top module: `spi_master_regs`

## Requirements
- R1: After reset every register reads zero, the serial clock is 0 and all four select lines are 0 (inactive with the active-low bit clear).
- R2: Writing 1 to bit 31 of the transfer register (offset 0x08) while the enable bit (bit 0) and the master bit (bit 1) of the global register (0x04) are set runs exactly N byte times, where N is the total count (0x30, 24 bits). Bit 31 reads 1 until the last byte is done. Every byte sent produces one byte received. With N = 0 bit 31 clears and no clock edge appears.
- R3: Bytes go out most significant bit first, 8 bits per byte.
- R4: Transfer bit 1 sets the serial clock idle level. With transfer bit 0 clear, data is sampled on the first edge of each bit. With it set, data is sampled on the second edge.
- R5: Only the first M bytes come from the transmit queue, where M is the queue count (0x34). Any later byte, or any byte for which the queue is empty, is sent as 0x00.
- R6: In automatic mode (transfer bit 6 = 0) only the line picked by transfer bits 5:4 is asserted, and only while an exchange runs. The asserted level is 0 when transfer bit 2 is set and 1 when it is clear. All other lines stay at the inactive level.
- R7: With transfer bit 6 set, the picked line is driven to transfer bit 7 and the other lines stay inactive.
- R8: Writing 1 to bit 15 of the queue control register (0x18) empties the receive queue, and writing 1 to bit 31 empties the transmit queue. Both bits read back 0.
- R9: Writing 1 to bit 31 of the global register aborts any exchange and empties both queues. The bit reads back 0.
- R10: A start written while the enable bit or the master bit is clear has no effect.
- R11: Each serial clock level lasts D+1 system clocks, where D is bits 7:0 of the clock register (0x24).
- R12: With global bit 7 set, the engine waits before a byte while the 64-entry receive queue is full. With it clear, bytes that arrive while the queue is full are dropped.
- R13: Status register (0x1C) bits 7:0 give the receive queue fill level and bits 23:16 give the transmit queue fill level. Pushes go to 0x200 and pops come from 0x300, a byte on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Select lines |

## Verification
The assertions assume that software leaves the mode, divider and counts alone while an exchange runs, and that the bus issues at most one access per cycle. The stimulus therefore changes configuration only between exchanges and performs only status polls and reset writes while the engine is busy. It changes the clock polarity only while the bit monitor is off, because a polarity change at idle moves the clock line. Serial input is the inverse of the serial output, so each received byte can be predicted from the byte sent.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam logic [11:0] ADDR_GLOBAL   = 12'h004;
  localparam logic [11:0] ADDR_XFER     = 12'h008;
  localparam logic [11:0] ADDR_QCTL     = 12'h018;
  localparam logic [11:0] ADDR_QSTAT    = 12'h01C;
  localparam logic [11:0] ADDR_CLKDIV   = 12'h024;
  localparam logic [11:0] ADDR_TOTAL    = 12'h030;
  localparam logic [11:0] ADDR_FROMQ    = 12'h034;
  localparam logic [11:0] ADDR_AUXCNT   = 12'h038;
  localparam logic [11:0] ADDR_TXPORT   = 12'h200;
  localparam logic [11:0] ADDR_RXPORT   = 12'h300;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_PUSH, ST_DONE
  } eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + AW'(1);
      if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= wdata;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R13
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_regs_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             pause_en,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] from_q,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  eng_state_t       state_q, state_d;
  logic [CNT_W-1:0] byte_q, byte_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [3:0]       edge_q, edge_d;
  logic [7:0]       sr_q, sr_d, rx_q, rx_d, nb;
  logic             phase_q, phase_d, mosi_q, mosi_d, use_q;

  assign sclk    = phase_q ^ cpol;
  assign mosi    = mosi_q;
  assign rx_data = rx_q;

  always_comb begin
    state_d = state_q;  byte_d = byte_q;  div_d = div_q;  edge_d = edge_q;
    sr_d = sr_q;  rx_d = rx_q;  phase_d = phase_q;  mosi_d = mosi_q;
    tx_pop = 1'b0;  rx_push = 1'b0;  done = 1'b0;
    use_q = 1'b0;  nb = 8'h00;
    if (clr || (!go && state_q != ST_IDLE)) begin
      state_d = ST_IDLE;
      phase_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) begin
          byte_d = '0;
          if (total == '0) begin
            done    = 1'b1;
            state_d = ST_DONE;
          end else state_d = ST_LOAD;
        end
        ST_LOAD: if (!(pause_en && rx_full)) begin
          use_q  = (byte_q < from_q) && !tx_empty;
          tx_pop = use_q;
          nb     = use_q ? tx_data : 8'h00;
          if (cpha) sr_d = nb;
          else begin
            mosi_d = nb[7];
            sr_d   = {nb[6:0], 1'b0};
          end
          edge_d  = '0;
          div_d   = '0;
          state_d = ST_SHIFT;
        end
        ST_SHIFT: if (div_q == div) begin
          div_d   = '0;
          phase_d = ~phase_q;
          edge_d  = edge_q + 4'd1;
          if (!edge_q[0]) begin
            if (cpha) begin
              mosi_d = sr_q[7];
              sr_d   = {sr_q[6:0], 1'b0};
            end else rx_d = {rx_q[6:0], miso};
          end else begin
            if (cpha) rx_d = {rx_q[6:0], miso};
            else if (edge_q != 4'd15) begin
              mosi_d = sr_q[7];
              sr_d   = {sr_q[6:0], 1'b0};
            end
          end
          if (edge_q == 4'd15) state_d = ST_PUSH;
        end else div_d = div_q + DIV_W'(1);
        ST_PUSH: begin
          rx_push = 1'b1;
          byte_d  = byte_q + CNT_W'(1);
          if (byte_q + CNT_W'(1) == total) begin
            done    = 1'b1;
            state_d = ST_DONE;
          end else state_d = ST_LOAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  byte_q <= '0;  div_q <= '0;  edge_q <= '0;
      sr_q <= '0;  rx_q <= '0;  phase_q <= 1'b0;  mosi_q <= 1'b0;
    end else begin
      state_q <= state_d;  byte_q <= byte_d;  div_q <= div_d;  edge_q <= edge_d;
      sr_q <= sr_d;  rx_q <= rx_d;  phase_q <= phase_d;  mosi_q <= mosi_d;
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (sclk == cpol)); // R4
  AST_BYTE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH) |-> (phase_q == 1'b0)); // R3
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && byte_q >= from_q) |-> !tx_pop); // R5
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && pause_en && rx_full && go && !clr) |=> (state_q == ST_LOAD)); // R12
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_regs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 24,
  parameter int DIV_W = 8,
  parameter int NCS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [11:0]    bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs
);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int SEL_W = $clog2(NCS);

  logic             rs_meta, rs_n;
  logic             wr, rd, srst, tx_clr, rx_clr;
  logic             en_q, en_d, mst_q, mst_d, tp_q, tp_d;
  logic             cpha_q, cpha_d, cpol_q, cpol_d, alow_q, alow_d;
  logic             man_q, man_d, lvl_q, lvl_d, start_q, start_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] tot_q, tot_d, frq_q, frq_d;
  logic [31:0]      aux_q, aux_d, rmux, rdata_q;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_push, rx_pop, rx_full, rx_empty, done;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [NCS-1:0]   cs_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign wr      = bus_sel && bus_we;
  assign rd      = bus_sel && !bus_we;
  assign srst    = wr && bus_addr == ADDR_GLOBAL && bus_wdata[31];
  assign tx_clr  = srst || (wr && bus_addr == ADDR_QCTL && bus_wdata[31]);
  assign rx_clr  = srst || (wr && bus_addr == ADDR_QCTL && bus_wdata[15]);
  assign tx_push = wr && bus_addr == ADDR_TXPORT;
  assign rx_pop  = rd && bus_addr == ADDR_RXPORT && !rx_empty;

  always_comb begin
    en_d = en_q;  mst_d = mst_q;  tp_d = tp_q;
    cpha_d = cpha_q;  cpol_d = cpol_q;  alow_d = alow_q;
    sel_d = sel_q;  man_d = man_q;  lvl_d = lvl_q;
    div_d = div_q;  tot_d = tot_q;  frq_d = frq_q;  aux_d = aux_q;
    if (wr) begin
      case (bus_addr)
        ADDR_GLOBAL: begin
          en_d = bus_wdata[0];  mst_d = bus_wdata[1];  tp_d = bus_wdata[7];
        end
        ADDR_XFER: begin
          cpha_d = bus_wdata[0];  cpol_d = bus_wdata[1];  alow_d = bus_wdata[2];
          sel_d  = bus_wdata[4 +: SEL_W];
          man_d  = bus_wdata[6];  lvl_d = bus_wdata[7];
        end
        ADDR_CLKDIV: div_d = bus_wdata[DIV_W-1:0];
        ADDR_TOTAL:  tot_d = bus_wdata[CNT_W-1:0];
        ADDR_FROMQ:  frq_d = bus_wdata[CNT_W-1:0];
        ADDR_AUXCNT: aux_d = bus_wdata;
        default: ;
      endcase
    end
    if (srst || !(en_q && mst_q) || done) start_d = 1'b0;
    else if (wr && bus_addr == ADDR_XFER && bus_wdata[31]) start_d = 1'b1;
    else start_d = start_q;
  end

  always_comb begin
    rmux = '0;
    case (bus_addr)
      ADDR_GLOBAL: rmux = {24'h0, tp_q, 5'h0, mst_q, en_q};
      ADDR_XFER: begin
        rmux = {start_q, 23'h0, lvl_q, man_q, 2'b00, 1'b0, alow_q, cpol_q, cpha_q};
        rmux[4 +: SEL_W] = sel_q;
      end
      ADDR_QSTAT: begin
        rmux[7:0]   = 8'(rx_cnt);
        rmux[23:16] = 8'(tx_cnt);
      end
      ADDR_CLKDIV: rmux[DIV_W-1:0] = div_q;
      ADDR_TOTAL:  rmux[CNT_W-1:0] = tot_q;
      ADDR_FROMQ:  rmux[CNT_W-1:0] = frq_q;
      ADDR_AUXCNT: rmux = aux_q;
      ADDR_RXPORT: rmux[7:0] = rx_empty ? 8'h00 : rx_head;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      en_q <= 1'b0;  mst_q <= 1'b0;  tp_q <= 1'b0;
      cpha_q <= 1'b0;  cpol_q <= 1'b0;  alow_q <= 1'b0;
      sel_q <= '0;  man_q <= 1'b0;  lvl_q <= 1'b0;  start_q <= 1'b0;
      div_q <= '0;  tot_q <= '0;  frq_q <= '0;  aux_q <= '0;  rdata_q <= '0;
    end else begin
      en_q <= en_d;  mst_q <= mst_d;  tp_q <= tp_d;
      cpha_q <= cpha_d;  cpol_q <= cpol_d;  alow_q <= alow_d;
      sel_q <= sel_d;  man_q <= man_d;  lvl_q <= lvl_d;  start_q <= start_d;
      div_q <= div_d;  tot_q <= tot_d;  frq_q <= frq_d;  aux_q <= aux_d;
      if (rd) rdata_q <= rmux;
    end
  end

  assign bus_rdata = rdata_q;

  spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rs_n), .clr(tx_clr), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rs_n), .clr(rx_clr), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_shift_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_eng (
    .clk(clk), .rst_n(rs_n), .clr(srst), .go(start_q), .cpol(cpol_q), .cpha(cpha_q),
    .pause_en(tp_q), .div(div_q), .total(tot_q), .from_q(frq_q),
    .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_byte), .done(done),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso));

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign spi_cs[g] = (sel_q == SEL_W'(g)) ? (man_q ? lvl_q : (start_q ? ~alow_q : alow_q))
                                            : alow_q;
  end

  assign cs_on = spi_cs ^ {NCS{alow_q}};

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rs_n)
    $onehot0(cs_on)); // R6
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rs_n)
    !(en_q && mst_q) |=> !start_q); // R10
  AST_TX_NO_DROP_FLAG: assert property (@(posedge clk) disable iff (!rs_n)
    (tx_full && !tx_pop && !tx_clr) |=> tx_full); // R13
endmodule

// File: tb/test_spi_master_regs.sv
module test_spi_master_regs;
  import spi_regs_pkg::*;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [7:0] div;
    logic [7:0] nb;
    logic [7:0] xm;
    logic [7:0] nload;
    logic [1:0] sel;
    logic [7:0] seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd0, 8'd4, 8'd4, 8'd4, 2'd0, 8'hA5},
    '{1'b0, 1'b1, 8'd1, 8'd3, 8'd3, 8'd3, 2'd1, 8'h3C},
    '{1'b1, 1'b0, 8'd2, 8'd5, 8'd2, 8'd5, 2'd2, 8'h81},
    '{1'b1, 1'b1, 8'd0, 8'd4, 8'd4, 8'd2, 2'd3, 8'hF0},
    '{1'b0, 1'b0, 8'd3, 8'd1, 8'd1, 8'd1, 2'd0, 8'h01},
    '{1'b1, 1'b1, 8'd0, 8'd8, 8'd8, 8'd8, 2'd1, 8'h5E}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic       mon_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] mon_sr;
  logic [7:0] mon_bytes [80];
  int mon_n = 0, mon_bits = 0, mon_edges = 0, pe_t = 0, last_pe = 0;

  assign spi_miso = ~spi_mosi;

  always #4 clk = ~clk;

  spi_master_regs i_spi_master_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs));

  always @(posedge clk) cyc++;

  always @(spi_sclk) begin
    if (mon_on) begin
      mon_edges++;
      if ((spi_sclk && m_cpol == m_cpha) || (!spi_sclk && m_cpol != m_cpha)) begin
        mon_sr = {mon_sr[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          if (mon_n < 80) mon_bytes[mon_n] = mon_sr;
          mon_n++;
          mon_bits = 0;
        end
      end
    end
  end

  always @(posedge spi_sclk) begin
    last_pe = pe_t;
    pe_t    = cyc;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1;  bus_we = 1'b1;  bus_addr = a;  bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;  bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1;  bus_we = 1'b0;  bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int k = 0; k < 4000; k++) begin
      bus_read(ADDR_XFER, r);
      if (!r[31]) return;
    end
  endtask

  task automatic mon_start(input logic pol, input logic pha);
    m_cpol = pol;  m_cpha = pha;
    mon_n = 0;  mon_bits = 0;  mon_edges = 0;  mon_on = 1'b1;
  endtask

  function automatic logic [7:0] tx_byte(input vec_t v, input int i);
    return v.seed + 8'(i * 37);
  endfunction

  function automatic logic [7:0] exp_byte(input vec_t v, input int i);
    return (i < int'(v.xm) && i < int'(v.nload)) ? tx_byte(v, i) : 8'h00;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] xw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 cs", {28'h0, spi_cs}, 32'h0);
    chk("R1 sclk", {31'h0, spi_sclk}, 32'h0);
    bus_read(ADDR_XFER, r);   chk("R1 xfer", r, 32'h0);
    bus_read(ADDR_QSTAT, r);  chk("R1 status", r, 32'h0);
    bus_read(ADDR_GLOBAL, r); chk("R1 global", r, 32'h0);

    // Vector table: R2 R3 R4 R5 R6 R13
    for (int vi = 0; vi < NV; vi++) begin
      vec_t v;
      v = VECS[vi];
      bus_write(ADDR_GLOBAL, 32'h8000_0003);
      bus_write(ADDR_CLKDIV, {24'h0, v.div});
      xw = {26'h0, v.sel, 1'b0, 1'b1, v.cpol, v.cpha};
      bus_write(ADDR_XFER, xw);
      for (int i = 0; i < int'(v.nload); i++) bus_write(ADDR_TXPORT, {24'h0, tx_byte(v, i)});
      bus_write(ADDR_TOTAL, {24'h0, v.nb});
      bus_write(ADDR_FROMQ, {24'h0, v.xm});
      mon_start(v.cpol, v.cpha);
      bus_write(ADDR_XFER, xw | 32'h8000_0000);
      chk("R6 cs during exchange", {28'h0, spi_cs}, {28'h0, 4'hF & ~(4'b0001 << v.sel)});
      wait_idle();
      mon_on = 1'b0;
      chk("R2 byte count", mon_n, {24'h0, v.nb});
      for (int i = 0; i < int'(v.nb); i++)
        chk("R3/R5 mosi byte", {24'h0, mon_bytes[i]}, {24'h0, exp_byte(v, i)});
      bus_read(ADDR_QSTAT, r);
      chk("R13 rx level", {24'h0, r[7:0]}, {24'h0, v.nb});
      for (int i = 0; i < int'(v.nb); i++) begin
        bus_read(ADDR_RXPORT, r);
        chk("R2 rx byte", r, {24'h0, ~exp_byte(v, i)});
      end
      chk("R4 idle level", {31'h0, spi_sclk}, {31'h0, v.cpol});
      chk("R6 cs after", {28'h0, spi_cs}, 32'hF);
    end

    // R11: divider
    bus_write(ADDR_GLOBAL, 32'h8000_0003);
    bus_write(ADDR_CLKDIV, 32'd4);
    bus_write(ADDR_XFER, 32'h0);
    bus_write(ADDR_TXPORT, 32'h5A);
    bus_write(ADDR_TOTAL, 32'd1);
    bus_write(ADDR_FROMQ, 32'd1);
    mon_start(1'b0, 1'b0);
    bus_write(ADDR_XFER, 32'h8000_0000);
    wait_idle();
    mon_on = 1'b0;
    chk("R11 sclk period", pe_t - last_pe, 32'd10);

    // R2: zero-length exchange
    bus_write(ADDR_TOTAL, 32'd0);
    mon_start(1'b0, 1'b0);
    bus_write(ADDR_XFER, 32'h8000_0000);
    repeat (4) @(negedge clk);
    bus_read(ADDR_XFER, r);
    mon_on = 1'b0;
    chk("R2 zero length busy", {31'h0, r[31]}, 32'h0);
    chk("R2 zero length edges", mon_edges, 32'h0);

    // R10: start ignored when disabled
    bus_write(ADDR_GLOBAL, 32'h8000_0002);
    bus_write(ADDR_TOTAL, 32'd2);
    mon_start(1'b0, 1'b0);
    bus_write(ADDR_XFER, 32'h8000_0000);
    bus_read(ADDR_XFER, r);
    chk("R10 start ignored", {31'h0, r[31]}, 32'h0);
    repeat (50) @(negedge clk);
    mon_on = 1'b0;
    chk("R10 no clock", mon_edges, 32'h0);
    bus_read(ADDR_QSTAT, r);
    chk("R10 no capture", r, 32'h0);

    // R12: pause when receive queue is full; R9: soft reset aborts
    bus_write(ADDR_GLOBAL, 32'h8000_0083);
    bus_write(ADDR_CLKDIV, 32'd0);
    bus_write(ADDR_TOTAL, 32'd66);
    bus_write(ADDR_FROMQ, 32'd0);
    bus_write(ADDR_XFER, 32'h8000_0000);
    repeat (3000) @(negedge clk);
    bus_read(ADDR_QSTAT, r);
    chk("R12 paused level", {24'h0, r[7:0]}, 32'd64);
    bus_read(ADDR_XFER, r);
    chk("R12 still busy", {31'h0, r[31]}, 32'h1);
    chk("R12 clock idle", {31'h0, spi_sclk}, 32'h0);
    bus_write(ADDR_GLOBAL, 32'h8000_0003);
    bus_read(ADDR_XFER, r);
    chk("R9 abort", {31'h0, r[31]}, 32'h0);
    bus_read(ADDR_QSTAT, r);
    chk("R9 queues empty", r, 32'h0);
    bus_read(ADDR_GLOBAL, r);
    chk("R9 bit self-clears", r, 32'h3);

    // R12: without pause the overflow is dropped
    bus_write(ADDR_XFER, 32'h8000_0000);
    wait_idle();
    bus_read(ADDR_QSTAT, r);
    chk("R12 drop level", {24'h0, r[7:0]}, 32'd64);

    // R8: queue resets
    bus_write(ADDR_QCTL, 32'h0000_8000);
    bus_read(ADDR_QSTAT, r);
    chk("R8 rx cleared", r, 32'h0);
    for (int i = 0; i < 3; i++) bus_write(ADDR_TXPORT, 32'(i));
    bus_read(ADDR_QSTAT, r);
    chk("R13 tx level", {24'h0, r[23:16]}, 32'd3);
    bus_write(ADDR_QCTL, 32'h8000_0000);
    bus_read(ADDR_QSTAT, r);
    chk("R8 tx cleared", r, 32'h0);
    bus_read(ADDR_QCTL, r);
    chk("R8 reads zero", r, 32'h0);

    // R7: manual select
    bus_write(ADDR_XFER, 32'h0000_0064);
    chk("R7 manual low", {28'h0, spi_cs}, 32'hB);
    bus_write(ADDR_XFER, 32'h0000_00E4);
    chk("R7 manual high", {28'h0, spi_cs}, 32'hF);
    bus_write(ADDR_XFER, 32'h0000_00D0);
    chk("R7 manual active-high", {28'h0, spi_cs}, 32'h2);

    finish_run();
  end
endmodule